// File: doc/BRIEF.md
# Limit-Match Counter/Timer

This block is a word-addressed counter/timer for a system bus. A counter held in the upper part of a 32-bit word moves forward by one unit each time an outside prescaler pulses the single-cycle `tick` input. When software programs a nonzero limit, the counter runs from zero up to one below the limit and then starts again. On the tick that closes each period it sets a sticky reached flag and raises a level interrupt. A limit of zero makes the counter run freely over its whole field without ever reporting a match.

Software acknowledges the interrupt by reading the limit word back. Two write offsets load the limit. One of them also restarts the period and the other leaves the running count alone, so a period can be retuned without a phase jump. A small mode word is plain storage. Its bits are driven out on `mode_out` for the per-processor timers next to this block.

Top module: `lmt_timer`

## Requirements
- R1: The count sits in bits [9 +: CNT_W] of the counter word (bits 30..9 by default). It goes up by one unit (0x200 at bit 9) in each cycle in which `tick` is high and holds otherwise. Bits 8..0 always read as zero.
- R2: Reading byte offset 0x04 returns the count in its field, with the reached flag in bit 31.
- R3: With a nonzero limit L, the tick that would take the count to L returns it to zero in that same edge and sets both the reached flag and `irq`, so each period is exactly L ticks. `irq` stays high until it is acknowledged.
- R4: With a limit of zero the count wraps from all ones to zero, and neither the reached flag nor `irq` is ever set.
- R5: Writing offset 0x00 loads the limit from wdata bits [9 +: CNT_W], clears the count to zero and drops `irq`, while the reached flag keeps its value. When such a write meets a matching tick in the same cycle, the write wins and no match is recorded.
- R6: Writing offset 0x08 loads the limit the same way, but the count, the reached flag and `irq` are untouched.
- R7: Reading offset 0x00 returns the limit in its field and clears both the reached flag and `irq`. When a match lands in the same cycle, the match wins and both stay set.
- R8: A write to offset 0x04 or to any undefined offset changes nothing. A read of 0x08, 0x0C or any offset other than 0x00, 0x04 and 0x10 returns zero.
- R9: Offset 0x10 holds an NPROC-bit mode word. A write stores wdata[NPROC-1:0], a read returns it zero-extended, and `mode_out` always shows it.
- R10: After reset, the limit, count, reached flag, `irq`, mode word and `rdata` are all zero, and the counter runs freely.
- R11: `rdata` is registered. It shows the word read in the cycle after `rd_en` and holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle count enable from the prescaler |
| wr_en | input | 1 | Word write strobe |
| rd_en | input | 1 | Word read strobe |
| addr | input | 5 | Byte offset of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| irq | output | 1 | Level interrupt on limit match |
| mode_out | output | NPROC | Stored mode word |

## Verification
The event that closes a period can land in the same cycle as a software action on the limit word. A read of offset 0x00 and a limit write can each coincide with the matching tick. The bench steers the count to one below a small limit and then issues the read or the write together with that tick. It expects the flags to survive the read and the restart to cancel the match. Random traffic with limits of a few units produces many more of these collisions, and every cycle is judged against a bench model built from the requirements.

// File: rtl/lmt_pkg.sv
package lmt_pkg;

    localparam int ADDR_W  = 5;
    localparam int FLD_LO  = 9;
    localparam int FLAG_BIT = 31;

    typedef enum logic [2:0] {
        SEL_LIMIT,
        SEL_COUNT,
        SEL_LIMIT_KEEP,
        SEL_MODE,
        SEL_NONE
    } sel_e;

    typedef struct packed {
        logic ld_restart;
        logic ld_keep;
        logic ack;
        logic mode_wr;
    } cmd_t;

    function automatic sel_e decode_offset(input logic [ADDR_W-1:0] a);
        case (a)
            5'h00:   return SEL_LIMIT;
            5'h04:   return SEL_COUNT;
            5'h08:   return SEL_LIMIT_KEEP;
            5'h10:   return SEL_MODE;
            default: return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/lmt_decode.sv
module lmt_decode
    import lmt_pkg::*;
(
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    output cmd_t              cmd,
    output sel_e              rsel
);
    sel_e sel;

    always_comb begin
        sel            = decode_offset(addr);
        rsel           = sel;
        cmd.ld_restart = wr_en && (sel == SEL_LIMIT);
        cmd.ld_keep    = wr_en && (sel == SEL_LIMIT_KEEP);
        cmd.ack        = rd_en && (sel == SEL_LIMIT);
        cmd.mode_wr    = wr_en && (sel == SEL_MODE);
    end
endmodule

// File: rtl/lmt_core.sv
module lmt_core
    import lmt_pkg::*;
#(
    parameter int CNT_W = 22
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  cmd_t             cmd,
    input  logic [CNT_W-1:0] new_lim,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] lim_q,
    output logic             reached_q,
    output logic             irq_q
);
    logic [CNT_W-1:0] cnt_nxt;
    logic             hit;

    always_comb begin
        cnt_nxt = cnt_q + CNT_W'(1);
        hit     = tick && (lim_q != '0) && (cnt_nxt == lim_q) && !cmd.ld_restart;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            lim_q <= '0;
        end else if (cmd.ld_restart) begin
            cnt_q <= '0;
            lim_q <= new_lim;
        end else begin
            if (cmd.ld_keep) lim_q <= new_lim;
            if (tick)        cnt_q <= hit ? '0 : cnt_nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            reached_q <= 1'b0;
            irq_q     <= 1'b0;
        end else begin
            if (hit)          reached_q <= 1'b1;
            else if (cmd.ack) reached_q <= 1'b0;
            if (hit)                              irq_q <= 1'b1;
            else if (cmd.ack || cmd.ld_restart)   irq_q <= 1'b0;
        end
    end

    p_irq_needs_tick_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_q) |-> $past(tick));

    p_irq_sticky_r3: assert property (@(posedge clk) disable iff (rst)
        (irq_q && !cmd.ack && !cmd.ld_restart) |=> irq_q);

    p_no_free_match_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(reached_q) |-> ($past(lim_q) != '0));

    p_restart_r5: assert property (@(posedge clk) disable iff (rst)
        cmd.ld_restart |=> (cnt_q == '0 && !irq_q));

    p_keep_count_r6: assert property (@(posedge clk) disable iff (rst)
        (cmd.ld_keep && !tick) |=> $stable(cnt_q));

    p_ack_clears_r7: assert property (@(posedge clk) disable iff (rst)
        (cmd.ack && !tick) |=> (!reached_q && !irq_q));
endmodule

// File: rtl/lmt_modereg.sv
module lmt_modereg #(
    parameter int NPROC = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic [NPROC-1:0] din,
    output logic [NPROC-1:0] mode_q
);
    always_ff @(posedge clk) begin
        if (rst)     mode_q <= '0;
        else if (wr) mode_q <= din;
    end

    p_mode_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !wr |=> $stable(mode_q));
endmodule

// File: rtl/lmt_timer.sv
module lmt_timer
    import lmt_pkg::*;
#(
    parameter int CNT_W = 22,
    parameter int NPROC = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic              irq,
    output logic [NPROC-1:0]  mode_out
);
    cmd_t             cmd;
    sel_e             rsel;
    logic [CNT_W-1:0] cnt_q, lim_q;
    logic             reached_q, irq_q;
    logic [NPROC-1:0] mode_q;
    logic [31:0]      rd_val, rdata_q;

    lmt_decode u_decode (
        .wr_en (wr_en),
        .rd_en (rd_en),
        .addr  (addr),
        .cmd   (cmd),
        .rsel  (rsel)
    );

    lmt_core #(.CNT_W(CNT_W)) u_core (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .cmd       (cmd),
        .new_lim   (wdata[FLD_LO +: CNT_W]),
        .cnt_q     (cnt_q),
        .lim_q     (lim_q),
        .reached_q (reached_q),
        .irq_q     (irq_q)
    );

    lmt_modereg #(.NPROC(NPROC)) u_mode (
        .clk    (clk),
        .rst    (rst),
        .wr     (cmd.mode_wr),
        .din    (wdata[NPROC-1:0]),
        .mode_q (mode_q)
    );

    always_comb begin
        rd_val = '0;
        case (rsel)
            SEL_LIMIT: rd_val[FLD_LO +: CNT_W] = lim_q;
            SEL_COUNT: begin
                rd_val[FLD_LO +: CNT_W] = cnt_q;
                rd_val[FLAG_BIT]        = reached_q;
            end
            SEL_MODE:  rd_val[NPROC-1:0] = mode_q;
            default:   rd_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)        rdata_q <= '0;
        else if (rd_en) rdata_q <= rd_val;
    end

    assign rdata    = rdata_q;
    assign irq      = irq_q;
    assign mode_out = mode_q;

    p_undef_zero_r8: assert property (@(posedge clk) disable iff (rst)
        (rd_en && (rsel == SEL_NONE || rsel == SEL_LIMIT_KEEP)) |=> (rdata == 32'h0));

    p_rdata_hold_r11: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rdata));
endmodule

// File: tb/lmt_timer_bench.sv
module lmt_timer_bench;
    localparam int W  = 8;
    localparam int NP = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          tick = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
    logic [4:0]    addr = '0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic          irq;
    logic [NP-1:0] mode_out;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    logic [W-1:0]  mcnt, mlim;
    logic          mrch, mirq;
    logic [NP-1:0] mmode;
    logic [31:0]   last_rd;

    always #4 clk = ~clk;

    lmt_timer #(.CNT_W(W), .NPROC(NP)) u_lmt_timer (
        .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq), .mode_out(mode_out)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] model_read(input logic [4:0] a);
        logic [31:0] v = '0;
        case (a)
            5'h00: v[9 +: W] = mlim;
            5'h04: begin v[9 +: W] = mcnt; v[31] = mrch; end
            5'h10: v[NP-1:0] = mmode;
            default: v = '0;
        endcase
        return v;
    endfunction

    task automatic model_edge(input bit tk, input bit wr, input bit rd,
                              input logic [4:0] a, input logic [31:0] d);
        logic [W-1:0] nx = mcnt + W'(1);
        bit restart = wr && (a == 5'h00);
        bit match   = tk && (mlim != '0) && (nx == mlim) && !restart;
        if (restart) begin
            mcnt = '0; mlim = d[9 +: W]; mirq = 1'b0;
        end else begin
            if (wr && a == 5'h08) mlim = d[9 +: W];
            if (tk) mcnt = match ? '0 : nx;
        end
        if (match) begin mrch = 1'b1; mirq = 1'b1; end
        else if (rd && a == 5'h00) begin mrch = 1'b0; mirq = 1'b0; end
        if (wr && a == 5'h10) mmode = d[NP-1:0];
    endtask

    task automatic step(input bit tk, input bit wr, input bit rd,
                        input logic [4:0] a, input logic [31:0] d, input string tag);
        logic [31:0] exp_rd;
        @(negedge clk);
        tick = tk; wr_en = wr; rd_en = rd; addr = a; wdata = d;
        exp_rd = model_read(a);
        @(posedge clk);
        model_edge(tk, wr, rd, a, d);
        #2;
        tick = 0; wr_en = 0; rd_en = 0;
        chk({tag, " irq"}, 32'(irq), 32'(mirq));
        chk("R9 mode_out", 32'(mode_out), 32'(mmode));
        if (rd) begin
            chk({tag, " rdata"}, rdata, exp_rd);
            last_rd = exp_rd;
        end else begin
            chk("R11 rdata hold", rdata, last_rd);
        end
    endtask

    function automatic logic [31:0] lim_word(input int units);
        logic [31:0] v = '0;
        v[9 +: W] = W'(units);
        return v;
    endfunction

    task automatic ticks(input int n, input string tag);
        for (int i = 0; i < n; i++) step(1, 0, 0, 5'h00, '0, tag);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240517));
        mcnt = '0; mlim = '0; mrch = 0; mirq = 0; mmode = '0; last_rd = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;

        // R10 reset state
        #1;
        chk("R10 irq after reset", 32'(irq), 32'h0);
        chk("R10 rdata after reset", rdata, 32'h0);
        chk("R10 mode after reset", 32'(mode_out), 32'h0);
        step(0, 0, 1, 5'h04, '0, "R10 count after reset");
        chk("R10 count zero", rdata, 32'h0);
        step(0, 0, 1, 5'h00, '0, "R10 limit after reset");

        // R1 / R2 counting and hold without tick
        ticks(5, "R1 tick");
        step(0, 0, 0, 5'h00, '0, "R1 idle");
        step(0, 0, 1, 5'h04, '0, "R2 count read");
        chk("R1 five ticks", rdata, 32'h0000_0A00);
        chk("R1 low bits zero", 32'(rdata[8:0]), 32'h0);

        // R4 free-run wrap
        ticks(251, "R4 free run");
        step(0, 0, 1, 5'h04, '0, "R4 wrap read");
        chk("R4 wrapped to zero", rdata, 32'h0);
        chk("R4 no irq", 32'(irq), 32'h0);

        // R3 periodic match, limit 4
        step(0, 1, 0, 5'h00, lim_word(4) | 32'h8000_01FF, "R5 write limit");
        ticks(3, "R3 below limit");
        chk("R3 no irq yet", 32'(irq), 32'h0);
        step(1, 0, 0, 5'h00, '0, "R3 match tick");
        chk("R3 irq raised", 32'(irq), 32'h1);
        step(0, 0, 1, 5'h04, '0, "R2 flag read");
        chk("R2 reached and zero count", rdata, 32'h8000_0000);
        ticks(4, "R3 second period");
        chk("R3 irq still high", 32'(irq), 32'h1);

        // R7 plain acknowledge
        step(0, 0, 1, 5'h00, '0, "R7 ack read");
        chk("R7 limit word", rdata, lim_word(4));
        chk("R7 irq cleared", 32'(irq), 32'h0);

        // R7 ack colliding with match
        ticks(3, "R7 approach");
        step(1, 0, 1, 5'h00, '0, "R7 ack with match");
        chk("R7 match wins", 32'(irq), 32'h1);
        step(0, 0, 1, 5'h04, '0, "R7 flag kept");
        chk("R7 reached kept", rdata, 32'h8000_0000);

        // R5 restart write colliding with match
        ticks(3, "R5 approach");
        step(1, 1, 0, 5'h00, lim_word(6), "R5 write with match");
        chk("R5 irq low", 32'(irq), 32'h0);
        step(0, 0, 1, 5'h04, '0, "R5 count restarted");
        chk("R5 count zero, flag kept", rdata, 32'h8000_0000);

        // R6 keep-count limit write
        ticks(2, "R6 advance");
        step(0, 1, 0, 5'h08, lim_word(3), "R6 keep write");
        step(0, 0, 1, 5'h04, '0, "R6 count kept");
        chk("R6 count two", rdata, 32'h8000_0400);
        step(1, 0, 0, 5'h00, '0, "R6 match new limit");
        chk("R6 new limit matches", 32'(irq), 32'h1);

        // R8 ignored write and undefined reads
        step(0, 1, 0, 5'h04, 32'h7FFF_FFFF, "R8 write counter");
        step(0, 0, 1, 5'h04, '0, "R8 count unchanged");
        chk("R8 count still zero", rdata, 32'h8000_0000);
        step(0, 1, 0, 5'h14, 32'hFFFF_FFFF, "R8 write undefined");
        step(0, 0, 1, 5'h0C, '0, "R8 read 0x0C");
        chk("R8 undefined zero", rdata, 32'h0);
        step(0, 0, 1, 5'h08, '0, "R8 read 0x08");
        chk("R8 keep offset reads zero", rdata, 32'h0);

        // R9 mode storage
        step(0, 1, 0, 5'h10, 32'hFFFF_FFF5, "R9 mode write");
        chk("R9 mode out", 32'(mode_out), 32'h5);
        step(0, 0, 1, 5'h10, '0, "R9 mode read");
        chk("R9 zero-extended", rdata, 32'h5);

        // random mix
        for (int i = 0; i < 4000; i++) begin
            logic [4:0]  alist [7] = '{5'h00, 5'h04, 5'h08, 5'h0C, 5'h10, 5'h14, 5'h01};
            logic [31:0] d  = $urandom;
            bit          tk = ($urandom % 2) == 0;
            int          r  = $urandom % 10;
            logic [4:0]  ra = alist[$urandom % 7];
            d[9 +: W] = W'($urandom % 13);
            case (r)
                4:       step(tk, 0, 1, ra,    d, "R3 R7 random read");
                5:       step(tk, 1, 0, 5'h00, d, "R5 random restart");
                6:       step(tk, 1, 0, 5'h08, d, "R6 random keep");
                7:       step(tk, 1, 0, 5'h04, d, "R8 random ignored");
                8:       step(tk, 1, 0, 5'h10, d, "R9 random mode");
                9:       step(tk, 1, 0, ra,    d, "R8 random write");
                default: step(tk, 0, 0, 5'h00, d, "R1 random idle");
            endcase
        end

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule